// File: doc/BRIEF.md
# Serial Flash Page Program Receiver

This block is the device-side front end of a serial NOR flash for the page program command. It watches an SPI bus in mode 0 (clock idle low, data sampled on the rising clock edge, most significant bit first). The bus pins are brought into the system clock domain through synchronizers, so the system clock must run several times faster than the serial clock. A transfer opens with a one-byte opcode and then a three-byte address. After that comes any number of data bytes, and these are gathered into a page-sized buffer.

The low address byte sets where the first data byte lands inside the page. Each following byte goes to the next location. Past the top of the page the write position wraps to the first location of the same page, so a long stream leaves the newest page-full of bytes in the buffer. A per-byte mask records which locations were written. The command is committed only when chip select returns high exactly on a byte boundary and at least one data byte has arrived. A commit raises a one-cycle request that carries the page base address, the whole buffer and the mask. The storage array behind the request merges only the masked bytes, so every location that was not sent keeps its old value.

Top module: `spi_page_prog_rx`

## Requirements
- R1: Only the opcode 02h, shifted in most significant bit first on rising serial clock edges while chip select is low, starts a page program. Any other opcode produces no request for that transfer.
- R2: The three bytes after the opcode form a 24-bit address, sent high byte first. `req_addr` equals that address with its low 8 bits forced to zero.
- R3: Data byte k of a transfer, counting from k = 0, is stored at page offset (A[7:0] + k) mod 256. Offset o appears in `req_data[o*8 +: 8]`.
- R4: When more than 256 data bytes arrive, each offset holds the last byte written to it, and every bit of `req_mask` is set.
- R5: When fewer than 256 data bytes arrive, `req_mask` bit o is 1 exactly for the offsets that were written. Bytes at cleared mask bits leave the storage array unchanged.
- R6: If chip select rises while a byte is partly shifted in (bit count not zero), or before the data phase begins, no request is issued.
- R7: If chip select rises with zero data bytes received, no request is issued.
- R8: A commit raises `req_valid` for exactly one clock cycle.
- R9: A falling chip select clears the bit counter and the written-byte mask. Bytes and partial bits left by an earlier aborted transfer therefore do not show up in the next request.
- R10: After the synchronous reset, `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock (mode 0) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the device |
| req_valid | output | 1 | One-cycle program request strobe |
| req_addr | output | 24 | Page base address (low 8 bits zero) |
| req_data | output | 2048 | Page buffer; offset o in bits o*8+7..o*8 |
| req_mask | output | 256 | Bit o set when offset o was written |

## Verification
The bench sweeps the starting offset over the bottom, middle and top of a page. For each start it sends lengths of one byte, a few bytes, exactly a page, one byte past a page and well past a page. A design that wraps to the next page, or keeps the oldest bytes instead of the newest, shows wrong data at the wrapped offsets. A design that misreports the mask would corrupt the byte-array model that holds untouched bytes. The bench also aborts transfers in three places: mid-byte, in the middle of the address, and with zero data bytes. A design that commits on any chip select rise issues a request where none is allowed. A follow-up command checks that stale mask bits from an aborted transfer are gone.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,   // not selected or command rejected
    ST_OPC,    // expecting the opcode byte
    ST_ADDR,   // collecting address bytes
    ST_DATA    // collecting payload bytes
  } cmd_st_t;
endpackage

// File: rtl/spi_pp_sync.sv
module spi_pp_sync (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_low,
  output logic mosi_s
);
  logic [2:0] sclk_q;
  logic [2:0] cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign cs_fall   = ~cs_q[1] & cs_q[2];
  assign cs_rise   = cs_q[1] & ~cs_q[2];
  assign cs_low    = ~cs_q[1];
  assign mosi_s    = mosi_q[1];
endmodule

// File: rtl/spi_pp_shift.sv
module spi_pp_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              din,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_out,
  output logic              aligned
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      sh        <= '0;
      byte_done <= 1'b0;
      byte_out  <= '0;
    end else begin
      byte_done <= 1'b0;
      if (clear) begin
        bit_cnt <= '0;
      end else if (shift_en) begin
        sh <= {sh[BYTE_W-2:0], din};
        if (bit_cnt == LAST) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
          byte_out  <= {sh[BYTE_W-2:0], din};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign aligned = (bit_cnt == '0);

  // R9: a new selection restarts bit alignment
  assert_align_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clear |=> aligned);
  // R6: a completed byte always leaves the counter on a boundary
  assert_done_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> aligned);
endmodule

// File: rtl/spi_pp_pagebuf.sv
module spi_pp_pagebuf #(
  parameter int PAGE_BYTES = 256,
  parameter int BYTE_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic                         load_ptr,
  input  logic [$clog2(PAGE_BYTES)-1:0] ptr_init,
  input  logic                         wr_en,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [PAGE_BYTES*BYTE_W-1:0] buf_flat,
  output logic [PAGE_BYTES-1:0]        mask
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  logic [BYTE_W-1:0] mem [PAGE_BYTES];
  logic [PG_W-1:0]   ptr;

  // payload storage: one write port, no reset, so it maps onto plain RAM bits
  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      mask <= '0;
    end else begin
      if (clear) mask <= '0;
      else if (wr_en) mask[ptr] <= 1'b1;
      if (load_ptr) ptr <= ptr_init;
      else if (wr_en) ptr <= ptr + 1'b1;   // natural wrap inside the page
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign buf_flat[g*BYTE_W +: BYTE_W] = mem[g];
  end

  // R9: mask is empty after a new selection
  assert_mask_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clear |=> (mask == '0));
  // R5: every write marks its own offset
  assert_write_marks_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clear) |=> mask[$past(ptr)]);
endmodule

// File: rtl/spi_page_prog_rx.sv
module spi_page_prog_rx #(
  parameter int          PAGE_BYTES = 256,
  parameter int          BYTE_W     = 8,
  parameter int          ADDR_W     = 24,
  parameter logic [7:0]  OPCODE     = 8'h02
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         spi_sclk,
  input  logic                         spi_cs_n,
  input  logic                         spi_mosi,
  output logic                         req_valid,
  output logic [ADDR_W-1:0]            req_addr,
  output logic [PAGE_BYTES*BYTE_W-1:0] req_data,
  output logic [PAGE_BYTES-1:0]        req_mask
);
  import spi_pp_pkg::*;

  localparam int PG_W       = $clog2(PAGE_BYTES);
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int AC_W       = $clog2(ADDR_BYTES + 1);
  localparam logic [AC_W-1:0] ADDR_LAST = AC_W'(ADDR_BYTES - 1);

  logic sclk_rise, cs_fall, cs_rise, cs_low, mosi_s;
  logic byte_done, aligned;
  logic [BYTE_W-1:0] byte_val;

  cmd_st_t          st;
  logic [AC_W-1:0]  addr_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_next;
  logic             any_data;
  logic             load_ptr, wr_en;

  spi_pp_sync u_sync (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cs_low(cs_low), .mosi_s(mosi_s)
  );

  spi_pp_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .clear(cs_fall), .shift_en(sclk_rise & cs_low),
    .din(mosi_s), .byte_done(byte_done), .byte_out(byte_val), .aligned(aligned)
  );

  assign addr_next = {addr_q[ADDR_W-BYTE_W-1:0], byte_val};
  assign load_ptr  = byte_done && (st == ST_ADDR) && (addr_cnt == ADDR_LAST);
  assign wr_en     = byte_done && (st == ST_DATA);

  spi_pp_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .BYTE_W(BYTE_W)) u_buf (
    .clk(clk), .rst(rst), .clear(cs_fall), .load_ptr(load_ptr),
    .ptr_init(addr_next[PG_W-1:0]), .wr_en(wr_en), .wr_data(byte_val),
    .buf_flat(req_data), .mask(req_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      addr_cnt  <= '0;
      addr_q    <= '0;
      any_data  <= 1'b0;
      req_valid <= 1'b0;
      req_addr  <= '0;
    end else begin
      req_valid <= 1'b0;
      if (cs_fall) begin
        st       <= ST_OPC;
        addr_cnt <= '0;
        any_data <= 1'b0;
      end else if (cs_rise) begin
        req_valid <= (st == ST_DATA) && aligned && any_data;
        req_addr  <= {addr_q[ADDR_W-1:PG_W], {PG_W{1'b0}}};
        st        <= ST_IDLE;
      end else if (byte_done && cs_low) begin
        unique case (st)
          ST_OPC:  st <= (byte_val == OPCODE) ? ST_ADDR : ST_IDLE;
          ST_ADDR: begin
            addr_q   <= addr_next;
            addr_cnt <= addr_cnt + 1'b1;
            if (addr_cnt == ADDR_LAST) st <= ST_DATA;
          end
          ST_DATA: any_data <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R8: strobe lasts one cycle
  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);
  // R7: a request always carries at least one written byte
  assert_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_mask != '0));
  // R2: the reported address is page aligned
  assert_page_base_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[PG_W-1:0] == '0));
  // R6: requests only follow a chip select release
  assert_commit_edge_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(cs_rise));
endmodule

// File: tb/spi_page_prog_rx_tb.sv
module spi_page_prog_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic         req_valid;
  logic [23:0]  req_addr;
  logic [2047:0] req_data;
  logic [255:0] req_mask;

  int checks = 0;
  int fails  = 0;
  int cmd_id = 0;
  logic [7:0] mem_dut [NPG*256];
  logic [7:0] mem_ref [NPG*256];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_page_prog_rx u_dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .req_mask(req_mask)
  );

  function automatic logic [7:0] pat(input int k, input int id);
    return 8'((k * 37 + id * 11 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 0; i < nb; i++) begin
      mosi = b[7-i];
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  // one transfer; expect_req tells whether a commit is allowed
  task automatic run_cmd(input logic [7:0] op, input int pg, input int start,
                         input int n, input int extra_bits, input int addr_bytes,
                         input bit expect_req, input string req);
    logic [23:0]  a;
    logic [255:0] exp_mask, got_mask, got_addr;
    logic [2047:0] got_data;
    int pulses, bad, d, k;
    a = 24'h3A0000 | 24'(pg << 8) | 24'(start);
    cmd_id++;
    pulses = 0; bad = 0;
    got_mask = '0; got_data = '0; got_addr = '0;
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    send_bits(op, 8);
    for (int i = 0; i < addr_bytes; i++) send_bits(a[23-8*i -: 8], 8);
    for (int i = 0; i < n; i++) send_bits(pat(i, cmd_id), 8);
    if (extra_bits > 0) send_bits(8'hA5, extra_bits);
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (req_valid) begin
        pulses++;
        got_mask = req_mask; got_data = req_data; got_addr = 256'(req_addr);
      end
    end
    if (!expect_req) begin
      chk(pulses == 0, req, "no request expected", 256'(pulses), 256'(0));
      return;
    end
    chk(pulses == 1, "R8", "request pulse count", 256'(pulses), 256'(1));
    chk(got_addr == 256'({a[23:8], 8'h00}), "R2", "page address",
        got_addr, 256'({a[23:8], 8'h00}));
    exp_mask = '0;
    for (int o = 0; o < 256; o++) begin
      d = (o - start + 256) % 256;
      if (d < n) begin
        exp_mask[o] = 1'b1;
        k = d + 256 * ((n - 1 - d) / 256);   // newest byte landing on o
        if (got_data[o*8 +: 8] !== pat(k, cmd_id)) bad++;
        mem_ref[pg*256 + o] = pat(k, cmd_id);
      end
      if (got_mask[o]) mem_dut[pg*256 + o] = got_data[o*8 +: 8];
    end
    chk(got_mask == exp_mask, (n > 255) ? "R4" : "R5", "written mask",
        got_mask, exp_mask);
    chk(bad == 0, "R3", "wrapped byte placement", 256'(bad), 256'(0));
    bad = 0;
    for (int o = 0; o < NPG*256; o++) if (mem_dut[o] !== mem_ref[o]) bad++;
    chk(bad == 0, "R5", "array model after merge", 256'(bad), 256'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int starts[3];
    int lens[5];
    int pg;
    starts = '{0, 128, 255};
    lens   = '{1, 3, 256, 257, 300};
    for (int i = 0; i < NPG*256; i++) begin
      mem_dut[i] = 8'((i * 3) ^ 8'h5A);
      mem_ref[i] = 8'((i * 3) ^ 8'h5A);
    end
    repeat (4) @(negedge clk);
    chk(req_valid == 1'b0, "R10", "req_valid in reset", 256'(req_valid), 256'(0));
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(req_valid == 1'b0, "R10", "req_valid after reset", 256'(req_valid), 256'(0));

    pg = 0;
    foreach (starts[s]) begin
      foreach (lens[l]) begin
        run_cmd(8'h02, pg % NPG, starts[s], lens[l], 0, 3, 1'b1, "R3");
        pg++;
      end
    end
    // R1: wrong opcode ignored
    run_cmd(8'h03, 1, 10, 4, 0, 3, 1'b0, "R1");
    run_cmd(8'h82, 1, 10, 4, 0, 3, 1'b0, "R1");
    // R6: release mid-byte and during the address
    run_cmd(8'h02, 2, 40, 2, 3, 3, 1'b0, "R6");
    run_cmd(8'h02, 2, 40, 0, 0, 2, 1'b0, "R6");
    // R7: no data bytes
    run_cmd(8'h02, 2, 40, 0, 0, 3, 1'b0, "R7");
    // R9: clean start after an aborted transfer that wrote bytes 40 and 41
    run_cmd(8'h02, 3, 40, 2, 5, 3, 1'b0, "R6");
    run_cmd(8'h02, 3, 200, 1, 0, 3, 1'b1, "R9");
    chk(req_mask[40] == 1'b0 && req_mask[200] == 1'b1, "R9",
        "stale mask after abort", 256'({req_mask[200], req_mask[40]}), 256'(2'b10));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule